// File: doc/BRIEF.md
# Recomputing Carry-Select Adder

This block adds two unsigned operands and a carry-in. The operand width is cut into equal sections, and every section forms its part of the sum in parallel with the others. A section has only one ripple-carry adder, and that adder always runs with a carry-in of zero. A small recomputing stage takes the zero-carry partial sum and derives the partial sum plus one, together with the carry-out that the section would give with a carry-in of one. The carry-out of the section below then selects one of the two candidates through a multiplexer. This replaces the second full adder that a classic carry-select adder needs.

The lowest section is selected directly by the global carry-in, so it acts as a plain adder with carry-in. The block has an optional output register for timing closure. When the register is enabled the result appears one clock after the operands, and reset clears it. The width must be a whole multiple of the section width. Elaboration stops with an error if it is not.

Top module: `rica_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals the (WIDTH+1)-bit value `op_a + op_b + carry_in` for every operand pair, with `carry_out` as bit WIDTH.
- R2: The lowest section is selected by `carry_in` alone: with both operands zero, `sum_out` equals `carry_in` and `carry_out` is 0.
- R3: In every section, the recomputed candidate equals the zero-carry partial sum plus one, modulo 2^SEC_W.
- R4: The carry-in-of-one carry-out of a section equals its zero-carry carry-out OR the all-ones condition of its zero-carry partial sum. A section whose partial sum is all ones therefore passes an incoming carry up to the next section.
- R5: Each section above the lowest is selected by the final carry-out of the section directly below it. A carry that is born in one section reaches the sections above it.
- R6: With OUT_REG=1 (default), outputs change only at a rising `clk` edge, one cycle after the operands. Reset asserted (`rst_n` low) drives both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Global carry-in |
| sum_out | output | WIDTH | Sum, modulo 2^WIDTH |
| carry_out | output | 1 | Final carry-out |

## Verification
The bench targets carries that must cross section boundaries. It uses an all-ones operand plus a carry-in, which ripples through every section, and a partial sum of exactly all ones that only the recomputed carry can pass upward. A design that forgot the all-ones term in the recomputed carry would drop the carry at the first boundary and return a sum with its upper sections too small by one. A design whose increment mask was off by one bit would corrupt the low bits whenever carry_in is 1. Alternating patterns and a carry generated inside an upper section check that selects are not swapped or shifted between neighbouring sections. Reset and the exact output cycle are checked so that a missing or doubled register stage shows up.

// File: rtl/rica_pkg.sv
package rica_pkg;

  // one-bit full adder, returns {carry, sum}
  function automatic logic [1:0] bit_add(input logic x, input logic y, input logic c);
    return {(x & y) | (x & c) | (y & c), x ^ y ^ c};
  endfunction

  // a bit of R flips in R+1 when every lower bit of R is one
  function automatic logic flip_next(input logic flip_below, input logic bit_below);
    return flip_below & bit_below;
  endfunction

  // pick between the two section candidates
  function automatic logic pick(input logic sel, input logic if_zero, input logic if_one);
    return sel ? if_one : if_zero;
  endfunction

endpackage

// File: rtl/rica_ripple.sv
module rica_ripple
  import rica_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;  // carry-in forced to zero

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign {chain[i+1], s[i]} = bit_add(a[i], b[i], chain[i]);
  end

  assign co = chain[W];
endmodule

// File: rtl/rica_recompute.sv
module rica_recompute
  import rica_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] r,
  input  logic         c0,
  output logic [W-1:0] r_inc,
  output logic         c1
);
  // flip[i]: bit i of r is inverted to form r+1
  logic [W:0] flip;
  assign flip[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_prefix
    assign flip[i+1] = flip_next(flip[i], r[i]);
  end

  assign r_inc = r ^ flip[W-1:0];
  // flip[W] is the all-ones condition of r
  assign c1 = c0 | flip[W];
endmodule

// File: rtl/rica_section.sv
module rica_section
  import rica_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co,
  output logic [W-1:0] dbg_r0,
  output logic [W-1:0] dbg_r1,
  output logic         dbg_c0,
  output logic         dbg_c1
);
  logic [W-1:0] r0, r1;
  logic         c0, c1;

  rica_ripple #(.W(W)) u_ripple (.a(a), .b(b), .s(r0), .co(c0));
  rica_recompute #(.W(W)) u_recomp (.r(r0), .c0(c0), .r_inc(r1), .c1(c1));

  for (genvar i = 0; i < W; i++) begin : g_mux
    assign s[i] = pick(sel, r0[i], r1[i]);
  end
  assign co = pick(sel, c0, c1);

  assign dbg_r0 = r0;
  assign dbg_r1 = r1;
  assign dbg_c0 = c0;
  assign dbg_c1 = c1;
endmodule

// File: rtl/rica_adder.sv
module rica_adder
  import rica_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int SEC_W   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int NSEC = WIDTH / SEC_W;

  if (WIDTH % SEC_W != 0) begin : g_bad_width
    $error("rica_adder: WIDTH must be a multiple of SEC_W");
  end

  // section-level events brought out for checking
  logic [SEC_W-1:0] sec_r0 [NSEC];
  logic [SEC_W-1:0] sec_r1 [NSEC];
  logic [SEC_W-1:0] sec_s  [NSEC];
  logic [NSEC-1:0]  sec_c0, sec_c1, sec_co, sec_sel;
  logic [WIDTH-1:0] comb_sum;
  logic             comb_cout;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    if (k == 0) begin : g_low
      assign sec_sel[k] = carry_in;
    end else begin : g_up
      assign sec_sel[k] = sec_co[k-1];
    end

    rica_section #(.W(SEC_W)) u_sec (
      .a      (op_a[k*SEC_W +: SEC_W]),
      .b      (op_b[k*SEC_W +: SEC_W]),
      .sel    (sec_sel[k]),
      .s      (sec_s[k]),
      .co     (sec_co[k]),
      .dbg_r0 (sec_r0[k]),
      .dbg_r1 (sec_r1[k]),
      .dbg_c0 (sec_c0[k]),
      .dbg_c1 (sec_c1[k])
    );
    assign comb_sum[k*SEC_W +: SEC_W] = sec_s[k];

    // R3: recomputed candidate is the zero-carry sum plus one
    a_r3_incr: assert property (@(posedge clk) disable iff (!rst_n)
      sec_r1[k] == SEC_W'(sec_r0[k] + 1'b1));
    // R4: carry-in-of-one carry-out includes the all-ones case
    a_r4_cout_one: assert property (@(posedge clk) disable iff (!rst_n)
      sec_c1[k] == (sec_c0[k] | (&sec_r0[k])));
    if (k > 0) begin : g_chk_sel
      // R5: upper section follows the carry-out below it
      a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
        sec_co[k-1] |-> (sec_s[k] == sec_r1[k]));
    end
  end

  assign comb_cout = sec_co[NSEC-1];

  // R1: whole-width result matches the arithmetic sum
  a_r1_sum: assert property (@(posedge clk) disable iff (!rst_n)
    {comb_cout, comb_sum} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
  // R2: lowest section is steered by carry_in
  a_r2_low: assert property (@(posedge clk) disable iff (!rst_n)
    sec_s[0] == (carry_in ? sec_r1[0] : sec_r0[0]));

  if (OUT_REG) begin : g_reg
    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_out   <= '0;
        carry_out <= 1'b0;
        started   <= 1'b0;
      end else begin
        sum_out   <= comb_sum;
        carry_out <= comb_cout;
        started   <= 1'b1;
      end
    end
    // R6: registered outputs lag the combinational result by one cycle
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ({carry_out, sum_out} == $past({comb_cout, comb_sum})));
  end else begin : g_comb
    assign sum_out   = comb_sum;
    assign carry_out = comb_cout;
  end
endmodule

// File: tb/rica_adder_tb.sv
`timescale 1ns/1ps
module rica_adder_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rica_adder #(.WIDTH(W), .SEC_W(4), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .carry_in(cin),
    .sum_out(sum), .carry_out(cout)
  );

  // {cin, a, b}
  localparam logic [32:0] VEC [0:9] = '{
    {1'b0, 16'h0000, 16'h0000},
    {1'b1, 16'hFFFF, 16'h0000},
    {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'hAAAA, 16'h5555},
    {1'b1, 16'hAAAA, 16'h5555},
    {1'b0, 16'h5555, 16'h5555},
    {1'b1, 16'h000F, 16'h0000},
    {1'b0, 16'h00F0, 16'h0010},
    {1'b1, 16'h0FFF, 16'hF000}
  };

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    check(req, {cout, sum}, model(x, y, c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R6: reset state
    a = 16'h1234; b = 16'h4321; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 reset", {cout, sum}, '0);
    rst_n = 1'b1;

    // R1/R4/R5: table walk
    for (int i = 0; i < 10; i++) begin
      apply("R1 table", VEC[i][31:16], VEC[i][15:0], VEC[i][32]);
    end

    // R2: lowest section driven by carry_in only
    apply("R2 cin only", 16'h0000, 16'h0000, 1'b1);
    apply("R2 cin zero", 16'h0000, 16'h0000, 1'b0);
    // R4: all-ones partial sum passes carry upward
    apply("R4 allones pass", 16'h0F0F, 16'h00F0, 1'b1);
    apply("R4 allones held", 16'h0F0F, 16'h00F0, 1'b0);
    // R5: carry born in a middle section reaches the top
    apply("R5 mid carry", 16'h0FF0, 16'h0010, 1'b0);
    apply("R5 full ripple", 16'h7FFF, 16'h0001, 1'b0);

    // R1: random operands
    for (int i = 0; i < 200; i++) begin
      apply("R1 random", W'($urandom), W'($urandom), 1'($urandom));
    end

    // R6: output holds until the next rising edge
    apply("R6 setup", 16'h1111, 16'h2222, 1'b0);
    @(negedge clk);
    a = 16'h0001; b = 16'h0001; cin = 1'b1;
    #1;
    check("R6 hold before edge", {cout, sum}, model(16'h1111, 16'h2222, 1'b0));
    @(negedge clk);
    check("R6 after edge", {cout, sum}, model(16'h0001, 16'h0001, 1'b1));

    // R6: reset clears a live result
    a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 reset clears", {cout, sum}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule